// File: doc/BRIEF.md
# Programming-Mode Address Pointer with Region-Aware Bulk Erase

This block sits in the serial programming path of a small flash microcontroller whose array holds 12-bit words in an 11-bit address space. It keeps the address pointer that the programming commands walk through. It decides, from where that pointer stands and from one protect bit, which parts of the array a bulk-erase clears. It also masks the words read back when user code protection is on. The array is represented by a synchronous memory model that stores loaded words and fills a whole region with ones when that region's erase enable is high.

A programming session starts with an entry pulse. The entry pulse parks the pointer on the configuration word at the top of the space. Increment strobes then step the pointer through user memory (0x000 to 0x3FF), the self-writable data block (0x400 to 0x43F), the ID words (0x440 to 0x443) and the backup calibration words (0x444 to 0x447). Addresses 0x448 and up are reserved, apart from the configuration word at 0x7FF. The configuration word can be reached only between entry and the first increment.

Read-back works as a small stream. A read request is a valid/ready handshake: it is taken when `rd_req_i` and `rd_req_rdy_o` are both high. The response is a registered word with `rd_valid_o`. That word holds until `rd_ready_i` is seen high. A new request is taken in the same cycle in which the pending response is consumed.

Top module: `pgm_ptr_ctrl`

## Requirements
- R1: After reset and after every entry pulse, `addr_o` is 0x7FF and `cfg_sel_o` is 1. The entry pulse takes effect on the next clock edge and wins over a simultaneous increment.
- R2: After any increment, `cfg_sel_o` stays 0 until the next entry pulse, including when the pointer wraps back to 0x7FF. A read at 0x7FF without the configuration selection returns 0x3FFF, and a load there is ignored.
- R3: Each increment adds one modulo 0x800. 0x3FF steps to 0x400, and 0x7FF steps to 0x000.
- R4: A bulk-erase strobe with the configuration word selected, or with the pointer in 0x000–0x3FF, raises `er_cfg_o` and `er_user_o`. It raises `er_data_o` only when `dp_i` is 0, and never raises `er_idcal_o`.
- R5: A bulk-erase strobe with the pointer in 0x400–0x43F raises only `er_data_o`, and only when `dp_i` is 1. With `dp_i` 0 it changes no stored word.
- R6: A bulk-erase strobe with the pointer in 0x440–0x447 raises only `er_idcal_o`, which clears both the ID and the calibration words. In the reserved range it raises nothing.
- R7: Each erase enable is high for exactly the one cycle after the strobe edge, and all enables are 0 in any cycle that does not follow a strobe. The memory region is all ones from the following edge on.
- R8: With `cp_n_i` 0, a read of 0x040–0x3FE returns 0x3000. Reads of 0x000–0x03F, 0x3FF, the data block, the IDs, the calibration words and the configuration word are never masked. With `cp_n_i` 1 nothing is masked.
- R9: `rd_data_o` bits 13:12 are always 1, and an erased or reserved location reads 0x3FFF. A taken request gives `rd_valid_o` on the next edge. The response holds, stable, while `rd_ready_i` is 0, and `rd_req_rdy_o` equals `!rd_valid_o || rd_ready_i`.
- R10: A load strobe `wr_i` stores `wr_data_i` at the pointer's location. In the reserved range the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_i | input | 1 | Programming-mode entry pulse |
| inc_i | input | 1 | Increment-pointer strobe |
| erase_i | input | 1 | Bulk-erase strobe |
| wr_i | input | 1 | Load-word strobe |
| wr_data_i | input | WORD_W | Word to store |
| cp_n_i | input | 1 | User code protection, 0 = protected |
| dp_i | input | 1 | Data-block protect bit from the configuration word |
| rd_req_i | input | 1 | Read request valid |
| rd_req_rdy_o | output | 1 | Read request ready |
| rd_ready_i | input | 1 | Read response ready |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | RD_W | Read response word, upper bits forced to 1 |
| addr_o | output | ADDR_W | Current pointer |
| cfg_sel_o | output | 1 | Configuration word currently selected |
| er_cfg_o | output | 1 | Erase enable, configuration word |
| er_user_o | output | 1 | Erase enable, user memory |
| er_data_o | output | 1 | Erase enable, data block |
| er_idcal_o | output | 1 | Erase enable, IDs and calibration words |

## Verification
The assertions assume that at most one of the entry, increment, erase and load strobes is high in any cycle, and that the entry pulse never coincides with an increment. Under those assumptions, the expected pointer and the erase decision follow from a single past cycle. The bench raises each strobe alone for one cycle, driven one nanosecond after a rising edge. It keeps the protect bits steady around every erase strobe and read request, so each enable and each masked word has one defined cause.

// File: rtl/pgm_ptr_pkg.sv
package pgm_ptr_pkg;
  typedef enum logic [2:0] {
    RG_USER  = 3'd0,
    RG_DATA  = 3'd1,
    RG_IDCAL = 3'd2,
    RG_RSVD  = 3'd3,
    RG_CFG   = 3'd4
  } region_e;

  typedef struct packed {
    logic cfg;
    logic user;
    logic data;
    logic idcal;
  } erase_t;
endpackage

// File: rtl/pgm_addr_ptr.sv
module pgm_addr_ptr
  import pgm_ptr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_BASE  = 1024,
  parameter int IDCAL_BASE = 1088,
  parameter int IDCAL_END  = 1096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o,
  output region_e           region_o
);
  localparam logic [ADDR_W-1:0] TOP_A = '1;
  localparam logic [ADDR_W-1:0] DB_A  = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] IB_A  = ADDR_W'(IDCAL_BASE);
  localparam logic [ADDR_W-1:0] IE_A  = ADDR_W'(IDCAL_END);

  logic [ADDR_W-1:0] ptr_q;
  logic              cfg_open_q;

  always_ff @(posedge clk) begin
    if (!rst_n || enter_i) begin
      ptr_q      <= TOP_A;
      cfg_open_q <= 1'b1;
    end else if (inc_i) begin
      ptr_q      <= ptr_q + 1'b1;
      cfg_open_q <= 1'b0;
    end
  end

  always_comb begin
    if (cfg_open_q && ptr_q == TOP_A) region_o = RG_CFG;
    else if (ptr_q < DB_A)            region_o = RG_USER;
    else if (ptr_q < IB_A)            region_o = RG_DATA;
    else if (ptr_q < IE_A)            region_o = RG_IDCAL;
    else                              region_o = RG_RSVD;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pgm_erase_sel.sv
module pgm_erase_sel
  import pgm_ptr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    erase_i,
  input  region_e region_i,
  input  logic    dp_i,
  output erase_t  er_o
);
  erase_t pick;
  erase_t er_q;

  always_comb begin
    pick = '0;
    unique case (region_i)
      RG_CFG, RG_USER: begin
        pick.cfg  = 1'b1;
        pick.user = 1'b1;
        pick.data = ~dp_i;
      end
      RG_DATA:  pick.data  = dp_i;
      RG_IDCAL: pick.idcal = 1'b1;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       er_q <= '0;
    else if (erase_i) er_q <= pick;
    else              er_q <= '0;
  end

  assign er_o = er_q;
endmodule

// File: rtl/pgm_mem_model.sv
module pgm_mem_model
  import pgm_ptr_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int WORD_W      = 12,
  parameter int USER_WORDS  = 1024,
  parameter int DATA_WORDS  = 64,
  parameter int IDCAL_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  region_e           region_i,
  input  erase_t            er_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam int UA_W = $clog2(USER_WORDS);
  localparam int DA_W = $clog2(DATA_WORDS);
  localparam int IA_W = $clog2(IDCAL_WORDS);
  localparam logic [ADDR_W-1:0] DB_A = ADDR_W'(USER_WORDS);
  localparam logic [ADDR_W-1:0] IB_A = ADDR_W'(USER_WORDS + DATA_WORDS);

  logic [WORD_W-1:0] user_q  [USER_WORDS];
  logic [WORD_W-1:0] data_q  [DATA_WORDS];
  logic [WORD_W-1:0] idcal_q [IDCAL_WORDS];
  logic [WORD_W-1:0] cfg_q;

  logic [ADDR_W-1:0] d_off, i_off;
  logic [UA_W-1:0]   u_idx;
  logic [DA_W-1:0]   d_idx;
  logic [IA_W-1:0]   i_idx;

  assign d_off = addr_i - DB_A;
  assign i_off = addr_i - IB_A;
  assign u_idx = UA_W'(addr_i);
  assign d_idx = DA_W'(d_off);
  assign i_idx = IA_W'(i_off);

  always_ff @(posedge clk) begin
    if (!rst_n || er_i.user) for (int k = 0; k < USER_WORDS; k++) user_q[k] <= '1;
    if (!rst_n || er_i.data) for (int k = 0; k < DATA_WORDS; k++) data_q[k] <= '1;
    if (!rst_n || er_i.idcal) for (int k = 0; k < IDCAL_WORDS; k++) idcal_q[k] <= '1;
    if (!rst_n || er_i.cfg) cfg_q <= '1;
    if (rst_n && wr_i) begin
      unique case (region_i)
        RG_USER:  user_q[u_idx]  <= wr_data_i;
        RG_DATA:  data_q[d_idx]  <= wr_data_i;
        RG_IDCAL: idcal_q[i_idx] <= wr_data_i;
        RG_CFG:   cfg_q          <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (region_i)
      RG_USER:  rd_word_o = user_q[u_idx];
      RG_DATA:  rd_word_o = data_q[d_idx];
      RG_IDCAL: rd_word_o = idcal_q[i_idx];
      RG_CFG:   rd_word_o = cfg_q;
      default:  rd_word_o = '1;
    endcase
  end
endmodule

// File: rtl/pgm_ptr_ctrl.sv
module pgm_ptr_ctrl
  import pgm_ptr_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int WORD_W      = 12,
  parameter int RD_W        = 14,
  parameter int USER_WORDS  = 1024,
  parameter int DATA_WORDS  = 64,
  parameter int IDCAL_WORDS = 8,
  parameter int OPEN_WORDS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  logic              inc_i,
  input  logic              erase_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              cp_n_i,
  input  logic              dp_i,
  input  logic              rd_req_i,
  output logic              rd_req_rdy_o,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [RD_W-1:0]   rd_data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cfg_sel_o,
  output logic              er_cfg_o,
  output logic              er_user_o,
  output logic              er_data_o,
  output logic              er_idcal_o
);
  localparam int DATA_BASE  = USER_WORDS;
  localparam int IDCAL_BASE = DATA_BASE + DATA_WORDS;
  localparam int IDCAL_END  = IDCAL_BASE + IDCAL_WORDS;
  localparam int PAD_W      = RD_W - WORD_W;
  localparam logic [ADDR_W-1:0] PROT_LO = ADDR_W'(OPEN_WORDS);
  localparam logic [ADDR_W-1:0] PROT_HI = ADDR_W'(USER_WORDS - 2);

  logic [ADDR_W-1:0] ptr;
  region_e           region;
  erase_t            er;
  logic [WORD_W-1:0] mem_word;

  pgm_addr_ptr #(
    .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE),
    .IDCAL_BASE(IDCAL_BASE), .IDCAL_END(IDCAL_END)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .inc_i(inc_i),
    .ptr_o(ptr), .region_o(region)
  );

  pgm_erase_sel u_erase (
    .clk(clk), .rst_n(rst_n), .erase_i(erase_i), .region_i(region),
    .dp_i(dp_i), .er_o(er)
  );

  pgm_mem_model #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .USER_WORDS(USER_WORDS),
    .DATA_WORDS(DATA_WORDS), .IDCAL_WORDS(IDCAL_WORDS)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .addr_i(ptr), .region_i(region), .er_i(er), .rd_word_o(mem_word)
  );

  logic            rsp_v_q;
  logic [RD_W-1:0] rsp_d_q;
  logic            take;
  logic            masked;

  assign rd_req_rdy_o = !rsp_v_q || rd_ready_i;
  assign take         = rd_req_i && rd_req_rdy_o;
  assign masked       = !cp_n_i && region == RG_USER && ptr >= PROT_LO && ptr <= PROT_HI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '1;
    end else if (take) begin
      rsp_v_q <= 1'b1;
      rsp_d_q <= {{PAD_W{1'b1}}, (masked ? {WORD_W{1'b0}} : mem_word)};
    end else if (rd_ready_i) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rd_valid_o = rsp_v_q;
  assign rd_data_o  = rsp_d_q;
  assign addr_o     = ptr;
  assign cfg_sel_o  = (region == RG_CFG);
  assign er_cfg_o   = er.cfg;
  assign er_user_o  = er.user;
  assign er_data_o  = er.data;
  assign er_idcal_o = er.idcal;
endmodule

// File: rtl/pgm_ptr_ctrl_chk.sv
module pgm_ptr_ctrl_chk #(
  parameter int ADDR_W      = 11,
  parameter int WORD_W      = 12,
  parameter int RD_W        = 14,
  parameter int USER_WORDS  = 1024,
  parameter int DATA_WORDS  = 64,
  parameter int IDCAL_WORDS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enter_i,
  input logic              inc_i,
  input logic              erase_i,
  input logic              dp_i,
  input logic              rd_ready_i,
  input logic              rd_valid_o,
  input logic [RD_W-1:0]   rd_data_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cfg_sel_o,
  input logic              er_cfg_o,
  input logic              er_user_o,
  input logic              er_data_o,
  input logic              er_idcal_o
);
  localparam logic [ADDR_W-1:0] TOP_A = '1;
  localparam logic [ADDR_W-1:0] DB_A  = ADDR_W'(USER_WORDS);
  localparam logic [ADDR_W-1:0] IB_A  = ADDR_W'(USER_WORDS + DATA_WORDS);
  localparam logic [ADDR_W-1:0] IE_A  = ADDR_W'(USER_WORDS + DATA_WORDS + IDCAL_WORDS);

  logic in_user, in_data, in_idcal;
  assign in_user  = cfg_sel_o || addr_o < DB_A;
  assign in_data  = !cfg_sel_o && addr_o >= DB_A && addr_o < IB_A;
  assign in_idcal = !cfg_sel_o && addr_o >= IB_A && addr_o < IE_A;

  // R1
  entry_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> (addr_o == TOP_A) && cfg_sel_o);

  // R2
  cfg_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !enter_i) |=> !cfg_sel_o);

  // R2
  cfg_stays_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel_o && !enter_i) |=> !cfg_sel_o);

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !enter_i) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  // R4
  user_erase_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_i && in_user) |=> er_cfg_o && er_user_o && !er_idcal_o && (er_data_o == !$past(dp_i)));

  // R5
  data_erase_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_i && in_data) |=> !er_cfg_o && !er_user_o && !er_idcal_o && (er_data_o == $past(dp_i)));

  // R6
  idcal_erase_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_i && in_idcal) |=> er_idcal_o && !er_cfg_o && !er_user_o && !er_data_o);

  // R7
  no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_i |=> !(er_cfg_o || er_user_o || er_data_o || er_idcal_o));

  // R9
  pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_data_o[RD_W-1:WORD_W] == '1));

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o && $stable(rd_data_o));
endmodule

bind pgm_ptr_ctrl pgm_ptr_ctrl_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .RD_W(RD_W),
  .USER_WORDS(USER_WORDS), .DATA_WORDS(DATA_WORDS), .IDCAL_WORDS(IDCAL_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .inc_i(inc_i), .erase_i(erase_i),
  .dp_i(dp_i), .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
  .addr_o(addr_o), .cfg_sel_o(cfg_sel_o), .er_cfg_o(er_cfg_o), .er_user_o(er_user_o),
  .er_data_o(er_data_o), .er_idcal_o(er_idcal_o)
);

// File: tb/tb_pgm_ptr_ctrl.sv
module tb_pgm_ptr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter_i = 0, inc_i = 0, erase_i = 0, wr_i = 0;
  logic [11:0] wr_data_i = '0;
  logic        cp_n_i = 1'b1, dp_i = 1'b1;
  logic        rd_req_i = 0, rd_ready_i = 0;
  logic        rd_req_rdy_o, rd_valid_o;
  logic [13:0] rd_data_o;
  logic [10:0] addr_o;
  logic        cfg_sel_o, er_cfg_o, er_user_o, er_data_o, er_idcal_o;

  pgm_ptr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .inc_i(inc_i), .erase_i(erase_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .cp_n_i(cp_n_i), .dp_i(dp_i),
    .rd_req_i(rd_req_i), .rd_req_rdy_o(rd_req_rdy_o), .rd_ready_i(rd_ready_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .addr_o(addr_o),
    .cfg_sel_o(cfg_sel_o), .er_cfg_o(er_cfg_o), .er_user_o(er_user_o),
    .er_data_o(er_data_o), .er_idcal_o(er_idcal_o)
  );

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int cur = 'h7FF;

  // Vector fields: {addr[37:27], cp_n[26], load word[25:14], expected read[13:0]}
  localparam logic [37:0] VEC [0:8] = '{
    {11'h03F, 1'b0, 12'h111, 14'h3111},
    {11'h040, 1'b0, 12'h222, 14'h3000},
    {11'h040, 1'b1, 12'h222, 14'h3222},
    {11'h200, 1'b0, 12'h0F0, 14'h3000},
    {11'h3FE, 1'b0, 12'h333, 14'h3000},
    {11'h3FF, 1'b0, 12'h444, 14'h3444},
    {11'h400, 1'b0, 12'h555, 14'h3555},
    {11'h442, 1'b0, 12'h666, 14'h3666},
    {11'h470, 1'b0, 12'h777, 14'h3FFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_enter();
    enter_i = 1; step(); enter_i = 0; cur = 'h7FF;
  endtask

  task automatic do_inc();
    inc_i = 1; step(); inc_i = 0; cur = (cur + 1) % 2048;
  endtask

  task automatic go(input int t);
    if (t == 'h7FF) do_enter();
    else begin
      if (cur == 'h7FF || t < cur) begin do_enter(); do_inc(); end
      while (cur != t) do_inc();
    end
  endtask

  task automatic do_write(input logic [11:0] d);
    wr_i = 1; wr_data_i = d; step(); wr_i = 0;
  endtask

  task automatic do_read(output logic [13:0] d);
    rd_req_i = 1; rd_ready_i = 1; step(); rd_req_i = 0;
    check("R9 valid after request", rd_valid_o, 1);
    d = rd_data_o;
    step(); rd_ready_i = 0;
  endtask

  task automatic do_erase(input string tag, input logic [3:0] exp);
    logic [13:0] unused_d;
    erase_i = 1; step(); erase_i = 0;
    check(tag, {er_cfg_o, er_user_o, er_data_o, er_idcal_o}, exp);
    step();
    check("R7 enables drop after one cycle", {er_cfg_o, er_user_o, er_data_o, er_idcal_o}, 0);
    unused_d = '0;
  endtask

  task automatic preload();
    cp_n_i = 1;
    do_enter(); do_write(12'h555);
    go('h010); do_write(12'h123);
    go('h400); do_write(12'h456);
    go('h441); do_write(12'h789);
    go('h445); do_write(12'h0AB);
  endtask

  task automatic verify(input string tag, input logic [13:0] c, input logic [13:0] u,
                        input logic [13:0] d, input logic [13:0] i, input logic [13:0] k);
    logic [13:0] r;
    cp_n_i = 1;
    do_enter(); do_read(r); check({tag, " cfg"}, r, c);
    go('h010); do_read(r); check({tag, " user"}, r, u);
    go('h400); do_read(r); check({tag, " data"}, r, d);
    go('h441); do_read(r); check({tag, " id"}, r, i);
    go('h445); do_read(r); check({tag, " cal"}, r, k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [13:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state: R1, R7, R9
    check("R1 reset pointer", addr_o, 'h7FF);
    check("R1 reset cfg select", cfg_sel_o, 1);
    check("R7 reset enables", {er_cfg_o, er_user_o, er_data_o, er_idcal_o}, 0);
    check("R9 reset no response", rd_valid_o, 0);
    check("R9 reset request ready", rd_req_rdy_o, 1);

    // R10: load and read the configuration word
    do_write(12'hABC); do_read(r);
    check("R10 cfg load readback", r, 14'h3ABC);
    do_inc();
    check("R3 wrap 7FF to 000", addr_o, 0);
    check("R2 cfg closed after increment", cfg_sel_o, 0);

    // Table walk: R8 protection, R10 reserved load ignored
    foreach (VEC[n]) begin
      go(int'(VEC[n][37:27]));
      cp_n_i = VEC[n][26];
      do_write(VEC[n][25:14]);
      do_read(r);
      check($sformatf("R8/R10 vector %0d at %0h", n, VEC[n][37:27]), r, VEC[n][13:0]);
    end
    cp_n_i = 1;

    // R3: 3FF steps to 400
    go('h3FF); do_inc();
    check("R3 3FF steps to 400", addr_o, 'h400);

    // R2: pointer back at 7FF by increments, config stays closed
    while (cur != 'h7FF) do_inc();
    check("R2 pointer at 7FF", addr_o, 'h7FF);
    check("R2 cfg not reselected", cfg_sel_o, 0);
    do_write(12'h000);
    do_read(r);
    check("R2 unselected 7FF reads ones", r, 14'h3FFF);
    do_enter(); do_read(r);
    check("R2 cfg untouched by load at 7FF", r, 14'h3ABC);
    check("R1 entry reselects cfg", cfg_sel_o, 1);

    // R9: back-pressure
    rd_req_i = 1; rd_ready_i = 0; step(); rd_req_i = 0;
    check("R9 response valid", rd_valid_o, 1);
    step();
    check("R9 held while not ready", {rd_valid_o, rd_data_o}, {1'b1, 14'h3ABC});
    check("R9 request blocked", rd_req_rdy_o, 0);
    rd_ready_i = 1; step(); rd_ready_i = 0;
    check("R9 consumed", rd_valid_o, 0);

    // R4: erase from cfg with dp=1
    preload(); do_enter(); dp_i = 1;
    do_erase("R4 cfg erase dp1 enables", 4'b1100);
    verify("R4 cfg erase dp1", 14'h3FFF, 14'h3FFF, 14'h3456, 14'h3789, 14'h30AB);

    // R4: erase from user memory with dp=0
    preload(); go('h100); dp_i = 0;
    do_erase("R4 user erase dp0 enables", 4'b1110);
    verify("R4 user erase dp0", 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3789, 14'h30AB);

    // R5: data region, dp=0 no effect, then dp=1 clears data only
    preload(); go('h420); dp_i = 0;
    do_erase("R5 data erase dp0 enables", 4'b0000);
    dp_i = 1;
    do_erase("R5 data erase dp1 enables", 4'b0010);
    verify("R5 data erase", 14'h3555, 14'h3123, 14'h3FFF, 14'h3789, 14'h30AB);

    // R6: ID/calibration region
    go('h446);
    do_erase("R6 idcal erase enables", 4'b0001);
    verify("R6 idcal erase", 14'h3555, 14'h3123, 14'h3FFF, 14'h3FFF, 14'h3FFF);

    // R6: reserved region erases nothing
    preload(); go('h460);
    do_erase("R6 reserved erase enables", 4'b0000);
    verify("R6 reserved erase", 14'h3555, 14'h3123, 14'h3456, 14'h3789, 14'h30AB);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule